// File: doc/BRIEF.md
# Aligned Block Transfer Segmenter

This block turns one request to move an arbitrary run of bytes in a 32-bit remote address space into a series of bus commands. Every command is naturally aligned, and the series uses as few commands as it can. A requester offers a start address, a byte count and a direction on a valid/ready port. The segmenter then presents one segment at a time on a second valid/ready port. Each segment carries a three-bit command code, the segment address and the segment byte count. A separate transfer engine executes each segment.

Each command size is chosen from the segment address modulo 8 and the bytes still owed. There are three sizes: two bytes, four bytes, and a burst that moves a multiple of eight bytes up to a cap. A read must have an even start address and an even length. A write must have an even start address. An odd write length is rounded up by one byte, and the final segment is flagged so the engine sends zero in that byte. A request with an illegal alignment is refused with a one-cycle error pulse. A request of zero length completes at once.

Top module: `xfer_splitter`

## Requirements
- R1: Command codes are 3 bits. The read codes are 0 for two bytes, 2 for four bytes and 4 for burst. Each write code is its read code plus one (1, 3, 5).
- R2: When the segment address modulo 8 is 2 or 6, or exactly 2 bytes remain, the segment is a two-byte command with length 2.
- R3: Otherwise, when the segment address modulo 8 is 4, or 6 or fewer bytes remain, the segment is a four-byte command with length 4.
- R4: Otherwise the segment is a burst. Its length is the remaining count rounded down to a multiple of 8, limited to BURST_MAX.
- R5: The first segment address equals the request address. Each later segment address equals the previous address plus the previous length. The lengths add up to the (padded) request length.
- R6: A read with an odd address or an odd length is refused: `err` pulses in the cycle after acceptance and no segment is issued.
- R7: A write with an odd address is refused the same way. A write with an odd length is extended by one byte, and `seg_pad` is high only on its final segment.
- R8: A legal zero-length request raises `done` in the cycle after acceptance and issues no segment.
- R9: `req_ready` is low from acceptance of a legal non-empty request until its last segment is accepted. `done` pulses in the cycle after that last acceptance, with `seg_valid` low.
- R10: While `seg_valid` is high and `seg_ready` is low, the segment fields stay unchanged in the next cycle.
- R11: During and right after reset, `req_ready` is 1 and `seg_valid`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Segmenter idle, request taken on this edge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Block start byte address |
| req_len | input | LEN_W | Block length in bytes |
| seg_valid | output | 1 | Segment presented |
| seg_ready | input | 1 | Engine takes the segment |
| seg_cmd | output | 3 | Command code |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | SEG_W | Segment byte count |
| seg_pad | output | 1 | Last byte of this segment is write padding (zero) |
| done | output | 1 | One-cycle pulse: request complete |
| err | output | 1 | One-cycle pulse: request refused |

## Verification
The main bench instance uses LEN_W = 7 and BURST_MAX = 24. The small cap lets the length limit bite in many requests. It also allows a sweep over every start offset 0 to 15 and every length 0 to 79, in both directions, plus the longest lengths. Every alignment and remainder combination, every refusal and every pad case are therefore reached, under a pseudo-random backpressure pattern on `seg_ready`. A second instance with the default parameters (16-bit length, cap 240) runs the 260-byte read at 0x60030002 and checks its six expected segments.

// File: rtl/xfer_splitter_pkg.sv
package xfer_splitter_pkg;

    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_RD16  = 3'd0,
        CMD_WR16  = 3'd1,
        CMD_RD32  = 3'd2,
        CMD_WR32  = 3'd3,
        CMD_RDBST = 3'd4,
        CMD_WRBST = 3'd5
    } cmd_e;

endpackage

// File: rtl/xfer_size_sel.sv
module xfer_size_sel
    import xfer_splitter_pkg::*;
#(
    parameter int REM_W     = 17,
    parameter int BURST_MAX = 240,
    parameter int SEG_W     = 8
) (
    input  logic [2:1]       off,
    input  logic [REM_W-1:0] rem,
    input  logic             is_write,
    output cmd_e             cmd,
    output logic [SEG_W-1:0] len
);
    logic [REM_W-1:0] floor8;
    cmd_e             base;

    always_comb begin
        floor8 = rem & ~REM_W'(7);
        if (off == 2'b01 || off == 2'b11 || rem == REM_W'(2)) begin
            base = CMD_RD16;
            len  = SEG_W'(2);
        end else if (off == 2'b10 || rem <= REM_W'(6)) begin
            base = CMD_RD32;
            len  = SEG_W'(4);
        end else begin
            base = CMD_RDBST;
            if (32'(floor8) > BURST_MAX) len = SEG_W'(BURST_MAX);
            else                         len = SEG_W'(floor8);
        end
        cmd = cmd_e'(base | {2'b00, is_write});
    end
endmodule

// File: rtl/xfer_req_check.sv
module xfer_req_check #(
    parameter int LEN_W = 16,
    parameter int REM_W = 17
) (
    input  logic             is_write,
    input  logic             addr_lsb,
    input  logic [LEN_W-1:0] len,
    output logic             reject,
    output logic             empty,
    output logic             pad,
    output logic [REM_W-1:0] total
);
    always_comb begin
        reject = addr_lsb | (~is_write & len[0]);
        empty  = (len == '0);
        pad    = is_write & len[0];
        total  = REM_W'(len) + REM_W'(pad);
    end
endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
    import xfer_splitter_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int BURST_MAX = 240,
    localparam int SEG_W    = $clog2(BURST_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [CMD_W-1:0]  seg_cmd,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [SEG_W-1:0]  seg_len,
    output logic              seg_pad,
    output logic              done,
    output logic              err
);
    localparam int REM_W = LEN_W + 1;

    typedef struct packed {
        logic              busy;
        logic              wr;
        logic              pad;
        logic [ADDR_W-1:0] addr;
        logic [REM_W-1:0]  rem;
        logic              done;
        logic              err;
    } state_t;

    state_t s_d, s_q;

    logic             chk_reject, chk_empty, chk_pad;
    logic [REM_W-1:0] chk_total;
    cmd_e             sel_cmd;
    logic [SEG_W-1:0] sel_len;
    logic             last_seg;

    xfer_req_check #(.LEN_W(LEN_W), .REM_W(REM_W)) i_check (
        .is_write (req_write),
        .addr_lsb (req_addr[0]),
        .len      (req_len),
        .reject   (chk_reject),
        .empty    (chk_empty),
        .pad      (chk_pad),
        .total    (chk_total)
    );

    xfer_size_sel #(.REM_W(REM_W), .BURST_MAX(BURST_MAX), .SEG_W(SEG_W)) i_sel (
        .off      (s_q.addr[2:1]),
        .rem      (s_q.rem),
        .is_write (s_q.wr),
        .cmd      (sel_cmd),
        .len      (sel_len)
    );

    assign last_seg = (s_q.rem == REM_W'(sel_len));

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        if (!s_q.busy) begin
            if (req_valid) begin
                if (chk_reject) begin
                    s_d.err = 1'b1;
                end else if (chk_empty) begin
                    s_d.done = 1'b1;
                end else begin
                    s_d.busy = 1'b1;
                    s_d.wr   = req_write;
                    s_d.pad  = chk_pad;
                    s_d.addr = req_addr;
                    s_d.rem  = chk_total;
                end
            end
        end else if (seg_ready) begin
            s_d.addr = s_q.addr + ADDR_W'(sel_len);
            s_d.rem  = s_q.rem - REM_W'(sel_len);
            if (last_seg) begin
                s_d.busy = 1'b0;
                s_d.pad  = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready = ~s_q.busy;
    assign seg_valid = s_q.busy;
    assign seg_cmd   = sel_cmd;
    assign seg_addr  = s_q.addr;
    assign seg_len   = sel_len;
    assign seg_pad   = s_q.busy & s_q.wr & s_q.pad & last_seg;
    assign done      = s_q.done;
    assign err       = s_q.err;
endmodule

// File: rtl/xfer_splitter_chk.sv
module xfer_splitter_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int SEG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LEN_W-1:0]  req_len,
    input logic              seg_valid,
    input logic              seg_ready,
    input logic [2:0]        seg_cmd,
    input logic [ADDR_W-1:0] seg_addr,
    input logic [SEG_W-1:0]  seg_len,
    input logic              seg_pad,
    input logic              done,
    input logic              err
);
    logic take_req, legal_req;
    assign take_req  = req_valid & req_ready;
    assign legal_req = ~req_addr[0] & (req_write | ~req_len[0]);

    p_code_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> seg_cmd <= 3'd5);

    p_two_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seg_cmd[2:1] == 2'b00) |-> (seg_len == SEG_W'(2) && !seg_addr[0]));

    p_four_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seg_cmd[2:1] == 2'b01) |-> (seg_len == SEG_W'(4) && seg_addr[1:0] == 2'b00));

    p_burst_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seg_cmd[2]) |-> (seg_len[2:0] == 3'b000 && seg_len != '0 && seg_addr[2:0] == 3'b000));

    p_first_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && legal_req && req_len != '0) |=> (seg_valid && seg_addr == $past(req_addr)));

    p_step_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seg_ready) |=> (!seg_valid || seg_addr == $past(seg_addr) + ADDR_W'($past(seg_len))));

    p_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && !legal_req) |=> (err && !seg_valid && !done));

    p_pad_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seg_pad |-> (seg_valid && seg_cmd[0]));

    p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && legal_req && req_len == '0) |=> (done && !seg_valid));

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> !req_ready);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!seg_valid && !err));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_cmd) && $stable(seg_addr) && $stable(seg_len)));
endmodule

bind xfer_splitter xfer_splitter_chk #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .SEG_W  (SEG_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .seg_valid (seg_valid),
    .seg_ready (seg_ready),
    .seg_cmd   (seg_cmd),
    .seg_addr  (seg_addr),
    .seg_len   (seg_len),
    .seg_pad   (seg_pad),
    .done      (done),
    .err       (err)
);

// File: tb/test_xfer_splitter.sv
module test_xfer_splitter;
    localparam int AW  = 32;
    localparam int LW  = 7;
    localparam int BM  = 24;
    localparam int SW  = $clog2(BM + 1);
    localparam int LWF = 16;
    localparam int SWF = $clog2(241);

    logic clk = 1'b0;
    always #5 clk = ~clk;
    logic rst_n = 1'b0;

    logic          a_req_valid = 1'b0, a_req_write = 1'b0, a_seg_ready = 1'b0;
    logic [AW-1:0] a_req_addr = '0;
    logic [LW-1:0] a_req_len = '0;
    logic          a_req_ready, a_seg_valid, a_seg_pad, a_done, a_err;
    logic [2:0]    a_seg_cmd;
    logic [AW-1:0] a_seg_addr;
    logic [SW-1:0] a_seg_len;

    logic           b_req_valid = 1'b0, b_seg_ready = 1'b0;
    logic [AW-1:0]  b_req_addr = '0;
    logic [LWF-1:0] b_req_len = '0;
    logic           b_req_ready, b_seg_valid, b_seg_pad, b_done, b_err;
    logic [2:0]     b_seg_cmd;
    logic [AW-1:0]  b_seg_addr;
    logic [SWF-1:0] b_seg_len;

    xfer_splitter #(.ADDR_W(AW), .LEN_W(LW), .BURST_MAX(BM)) i_xfer_splitter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(a_req_valid), .req_ready(a_req_ready), .req_write(a_req_write),
        .req_addr(a_req_addr), .req_len(a_req_len),
        .seg_valid(a_seg_valid), .seg_ready(a_seg_ready), .seg_cmd(a_seg_cmd),
        .seg_addr(a_seg_addr), .seg_len(a_seg_len), .seg_pad(a_seg_pad),
        .done(a_done), .err(a_err));

    xfer_splitter #(.ADDR_W(AW), .LEN_W(LWF), .BURST_MAX(240)) i_xfer_splitter_full (
        .clk(clk), .rst_n(rst_n),
        .req_valid(b_req_valid), .req_ready(b_req_ready), .req_write(1'b0),
        .req_addr(b_req_addr), .req_len(b_req_len),
        .seg_valid(b_seg_valid), .seg_ready(b_seg_ready), .seg_cmd(b_seg_cmd),
        .seg_addr(b_seg_addr), .seg_len(b_seg_len), .seg_pad(b_seg_pad),
        .done(b_done), .err(b_err));

    int n_chk = 0;
    int n_fail = 0;
    int lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit next_ready();
        lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
        return (lfsr & 3) != 0;
    endfunction

    // expected command and length from R1 to R4
    function automatic void pick(input int off, input int rem, input bit wr, input int cap,
                                 output int cmd, output int len);
        if (off == 2 || off == 6 || rem == 2) begin
            cmd = 0; len = 2;
        end else if (off == 4 || rem <= 6) begin
            cmd = 2; len = 4;
        end else begin
            cmd = 4; len = (rem / 8) * 8;
            if (len > cap) len = cap;
        end
        cmd = cmd + int'(wr);
    endfunction

    task automatic run_small(input int addr, input int len, input bit wr);
        int e_cmd[64];
        int e_addr[64];
        int e_len[64];
        int n = 0;
        int cur = addr;
        int rem;
        int idx = 0;
        int guard = 0;
        bit hold = 0;
        bit pad_req = wr && (len % 2 == 1);
        bit refuse = (addr % 2 == 1) || (!wr && (len % 2 == 1));
        logic [2:0]    h_cmd;
        logic [AW-1:0] h_addr;
        logic [SW-1:0] h_len;
        rem = len + int'(pad_req);
        @(negedge clk);
        chk(a_req_ready == 1'b1, "R9", "ready when idle", a_req_ready, 1);
        a_req_valid = 1'b1; a_req_write = wr;
        a_req_addr = AW'(addr); a_req_len = LW'(len);
        @(negedge clk);
        a_req_valid = 1'b0;
        if (refuse) begin
            chk(a_err == 1'b1 && a_seg_valid == 1'b0 && a_done == 1'b0,
                wr ? "R7" : "R6", "refusal pulse", {a_err, a_seg_valid, a_done}, 3'b100);
            return;
        end
        if (len == 0) begin
            chk(a_done == 1'b1 && a_seg_valid == 1'b0, "R8", "empty request done",
                {a_done, a_seg_valid}, 2'b10);
            return;
        end
        while (rem > 0) begin
            int c, l;
            pick(cur % 8, rem, wr, BM, c, l);
            e_cmd[n] = c; e_addr[n] = cur; e_len[n] = l;
            n++; cur += l; rem -= l;
        end
        while (idx < n) begin
            bit rdy;
            guard++;
            if (guard > 2000 || !a_seg_valid) begin
                chk(1'b0, "R9", "segment missing", idx, n);
                a_seg_ready = 1'b0;
                return;
            end
            chk(a_req_ready == 1'b0, "R9", "busy blocks request", a_req_ready, 0);
            if (hold) begin
                chk(a_seg_cmd == h_cmd && a_seg_addr == h_addr && a_seg_len == h_len,
                    "R10", "held segment", a_seg_addr, h_addr);
            end
            rdy = next_ready();
            a_seg_ready = rdy;
            if (rdy) begin
                string tag;
                tag = (e_len[idx] == 2) ? "R1 R2" : (e_len[idx] == 4) ? "R1 R3" : "R1 R4";
                chk(int'(a_seg_cmd) == e_cmd[idx], tag, "command", a_seg_cmd, e_cmd[idx]);
                chk(int'(a_seg_len) == e_len[idx], tag, "length", a_seg_len, e_len[idx]);
                chk(a_seg_addr == AW'(e_addr[idx]), "R5", "address", a_seg_addr, e_addr[idx]);
                chk(a_seg_pad == (pad_req && idx == n - 1), "R7", "pad flag",
                    a_seg_pad, pad_req && idx == n - 1);
                idx++;
                hold = 0;
            end else begin
                hold = 1;
                h_cmd = a_seg_cmd; h_addr = a_seg_addr; h_len = a_seg_len;
            end
            @(negedge clk);
        end
        a_seg_ready = 1'b0;
        chk(a_done == 1'b1 && a_seg_valid == 1'b0, "R9", "done after last segment",
            {a_done, a_seg_valid}, 2'b10);
    endtask

    task automatic run_example();
        int x_addr[6] = '{32'h60030002, 32'h60030004, 32'h60030008,
                          32'h600300F8, 32'h60030100, 32'h60030104};
        int x_cmd[6]  = '{0, 2, 4, 4, 2, 0};
        int x_len[6]  = '{2, 4, 240, 8, 4, 2};
        @(negedge clk);
        b_req_valid = 1'b1; b_req_addr = 32'h60030002; b_req_len = 16'd260;
        b_seg_ready = 1'b1;
        @(negedge clk);
        b_req_valid = 1'b0;
        for (int i = 0; i < 6; i++) begin
            chk(b_seg_valid && int'(b_seg_cmd) == x_cmd[i] && int'(b_seg_len) == x_len[i],
                "R4", "example command/length", {b_seg_cmd, b_seg_len}, {x_cmd[i][2:0], x_len[i][7:0]});
            chk(b_seg_addr == AW'(x_addr[i]), "R5", "example address", b_seg_addr, x_addr[i]);
            @(negedge clk);
        end
        b_seg_ready = 1'b0;
        chk(b_done == 1'b1 && b_seg_valid == 1'b0, "R9", "example done", b_done, 1);
    endtask

    task automatic main_seq();
        repeat (3) @(negedge clk);
        chk(a_req_ready && !a_seg_valid && !a_done && !a_err, "R11", "state in reset",
            {a_req_ready, a_seg_valid, a_done, a_err}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(a_req_ready && !a_seg_valid && !a_done && !a_err, "R11", "state after reset",
            {a_req_ready, a_seg_valid, a_done, a_err}, 4'b1000);
        for (int wr = 0; wr < 2; wr++)
            for (int off = 0; off < 16; off++)
                for (int len = 0; len < 80; len++)
                    run_small(32'h0001_2340 + off, len, wr[0]);
        for (int off = 0; off < 8; off++) begin
            run_small(32'h0000_7FF0 + off, 127, 1'b1);
            run_small(32'h0000_7FF0 + off, 126, 1'b0);
            run_small(32'h0000_7FF0 + off, 127, 1'b0);
        end
        run_example();
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (190000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL R9 watchdog: actual %0d expected %0d", 190000, 0);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule